// File: doc/BRIEF.md
# Selectable Edge Trigger with Hysteresis

This block watches two signed 14-bit sample streams and two asynchronous trigger wires, and emits a one-clock trigger pulse to a capture controller. A 3-bit source code chooses what counts as an event. The choices are nothing, an immediate shot, a rising or falling level crossing on either channel, or a rising edge on either external wire. Arming and storage live elsewhere; this block only decides the instant.

Each channel has its own threshold and its own hysteresis width. After a crossing has fired, that direction's detector is blocked. It is released only when the signal has moved back beyond the threshold by more than the hysteresis width. Noise around the level therefore cannot produce a burst of triggers. Both channels' rising and falling detectors run at all times, whatever the source code, so changing the code never resets their history.

The sample interface carries a valid strobe but no ready. The block accepts every sample in the cycle it is presented and never applies back-pressure. Cycles with the strobe low do not advance the crossing logic.

Top module: `trigger_select`

## Requirements
- R1: While `rst_n` is low, `trig_o` is 0. After reset, all crossing detectors are blocked until re-released by a valid sample, and the external-edge history is zero.
- R2: With source code 0, `trig_o` stays 0 whatever the inputs do.
- R3: Code 1 (immediate) produces one pulse in the cycle after the first clock edge at which the code is 1, provided the code was not 1 at the previous edge (reset counts as code 0). Holding code 1 produces no further pulses.
- R4: Codes 2 (channel A) and 4 (channel B) select rising crossings. A valid sample that is strictly below threshold minus hysteresis releases the detector. A released detector fires on a valid sample that is at or above the threshold, and `trig_o` is high in the following cycle. Samples and thresholds compare as two's complement; hysteresis is unsigned.
- R5: Codes 3 (channel A) and 5 (channel B) select falling crossings. A valid sample strictly above threshold plus hysteresis releases the detector. A released detector fires on a valid sample at or below the threshold, with the same one-cycle latency as R4.
- R6: Firing blocks that detector again, so repeated samples near the threshold produce no further pulse until release.
- R7: A sample with `smp_valid` low neither fires nor releases any detector.
- R8: Codes 6 and 7 select external inputs 0 and 1. Each input passes through a two-flop synchroniser and fires on its rising edge. `trig_o` is high after the third rising clock edge at which the input is high.
- R9: With the source code unchanged, every pulse on `trig_o` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Both channel samples valid this cycle |
| ch_a_smp | input | 14 | Channel A sample, two's complement |
| ch_b_smp | input | 14 | Channel B sample, two's complement |
| ext_trig_in | input | 2 | Asynchronous external trigger wires |
| src_sel | input | 3 | Source code: 0 off, 1 now, 2/3 A up/down, 4/5 B up/down, 6/7 external 0/1 |
| thr_a | input | 14 | Channel A threshold, two's complement |
| thr_b | input | 14 | Channel B threshold, two's complement |
| hyst_a | input | 14 | Channel A hysteresis, unsigned |
| hyst_b | input | 14 | Channel B hysteresis, unsigned |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A detector stuck released shows up as extra pulses on the next valid sample at or past the threshold. A detector stuck blocked shows up as a crossing that never fires. Both are visible one cycle after the offending sample. A wrong signed compare or hysteresis sign shifts the firing or release sample in a threshold and hysteresis sweep, which moves a pulse by at least one sample. A synchroniser of the wrong depth moves external pulses by a whole cycle.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int unsigned SRC_W = 3;
  localparam int unsigned N_CH  = 2;
  localparam int unsigned N_EXT = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 3'd0,
    SRC_NOW  = 3'd1,
    SRC_A_UP = 3'd2,
    SRC_A_DN = 3'd3,
    SRC_B_UP = 3'd4,
    SRC_B_DN = 3'd5,
    SRC_X0   = 3'd6,
    SRC_X1   = 3'd7
  } trg_src_e;
endpackage

// File: rtl/trg_level_cross.sv
module trg_level_cross #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] thr,
  input  logic [DW-1:0] hyst,
  output logic          up_hit,
  output logic          dn_hit
);
  localparam int EW = DW + 2;

  logic signed [EW-1:0] s_x, t_x, h_x, lo_x, hi_x;
  logic up_rel, dn_rel;

  always_comb begin
    s_x  = $signed({{2{sample[DW-1]}}, sample});
    t_x  = $signed({{2{thr[DW-1]}}, thr});
    h_x  = $signed({2'b00, hyst});
    lo_x = t_x - h_x;
    hi_x = t_x + h_x;
  end

  assign up_hit = valid && up_rel && (s_x >= t_x);
  assign dn_hit = valid && dn_rel && (s_x <= t_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_rel <= 1'b0;
      dn_rel <= 1'b0;
    end else if (valid) begin
      up_rel <= (s_x < lo_x) || (up_rel && !(s_x >= t_x));
      dn_rel <= (s_x > hi_x) || (dn_rel && !(s_x <= t_x));
    end
  end
endmodule

// File: rtl/trg_ext_edge.sv
module trg_ext_edge #(
  parameter int N    = 2,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ext,
  output logic [N-1:0] rise
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_in
      logic [SYNC:0] sh;
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC-1:0], ext[g]};
      end
      assign rise[g] = sh[SYNC-1] && !sh[SYNC];
    end
  endgenerate
endmodule

// File: rtl/trigger_select.sv
module trigger_select
  import trg_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] ch_a_smp,
  input  logic [DW-1:0] ch_b_smp,
  input  logic [1:0]    ext_trig_in,
  input  logic [2:0]    src_sel,
  input  logic [DW-1:0] thr_a,
  input  logic [DW-1:0] thr_b,
  input  logic [DW-1:0] hyst_a,
  input  logic [DW-1:0] hyst_b,
  output logic          trig_o
);
  logic [DW-1:0] smp_v  [N_CH];
  logic [DW-1:0] thr_v  [N_CH];
  logic [DW-1:0] hyst_v [N_CH];
  logic [N_CH-1:0]  up_hit, dn_hit;
  logic [N_EXT-1:0] ext_rise;
  trg_src_e src, src_prev;
  logic now_hit, sel_hit;

  assign smp_v[0]  = ch_a_smp;
  assign smp_v[1]  = ch_b_smp;
  assign thr_v[0]  = thr_a;
  assign thr_v[1]  = thr_b;
  assign hyst_v[0] = hyst_a;
  assign hyst_v[1] = hyst_b;

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      trg_level_cross #(.DW(DW)) u_cross (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (smp_valid),
        .sample (smp_v[c]),
        .thr    (thr_v[c]),
        .hyst   (hyst_v[c]),
        .up_hit (up_hit[c]),
        .dn_hit (dn_hit[c])
      );
    end
  endgenerate

  trg_ext_edge #(.N(N_EXT), .SYNC(2)) u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .ext   (ext_trig_in),
    .rise  (ext_rise)
  );

  assign src     = trg_src_e'(src_sel);
  assign now_hit = (src == SRC_NOW) && (src_prev != SRC_NOW);

  always_comb begin
    unique case (src)
      SRC_OFF:  sel_hit = 1'b0;
      SRC_NOW:  sel_hit = now_hit;
      SRC_A_UP: sel_hit = up_hit[0];
      SRC_A_DN: sel_hit = dn_hit[0];
      SRC_B_UP: sel_hit = up_hit[1];
      SRC_B_DN: sel_hit = dn_hit[1];
      SRC_X0:   sel_hit = ext_rise[0];
      SRC_X1:   sel_hit = ext_rise[1];
      default:  sel_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev <= SRC_OFF;
      trig_o   <= 1'b0;
    end else begin
      src_prev <= src;
      trig_o   <= sel_hit;
    end
  end
endmodule

// File: rtl/trigger_select_chk.sv
module trigger_select_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [DW-1:0] ch_a_smp,
  input logic [DW-1:0] ch_b_smp,
  input logic [1:0]    ext_trig_in,
  input logic [2:0]    src_sel,
  input logic [DW-1:0] thr_a,
  input logic [DW-1:0] thr_b,
  input logic [DW-1:0] hyst_a,
  input logic [DW-1:0] hyst_b,
  input logic          trig_o
);
  always @(negedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!trig_o); // R1
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd0) |=> !trig_o); // R2

  AST_NOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd1 && $past(src_sel) != 3'd1) |=> trig_o); // R3

  AST_UP_BELOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd2 && $signed(ch_a_smp) < $signed(thr_a)) |=> !trig_o); // R4

  AST_DN_ABOVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd5 && $signed(ch_b_smp) > $signed(thr_b)) |=> !trig_o); // R5

  AST_IDLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel >= 3'd2 && src_sel <= 3'd5 && !smp_valid) |=> !trig_o); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $stable(src_sel)) |=> !trig_o); // R9
endmodule

bind trigger_select trigger_select_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_trigger_select.sv
module sim_trigger_select;
  localparam int CLK_NS = 10;
  localparam int DW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] ch_a_smp = '0, ch_b_smp = '0, thr_a = '0, thr_b = '0, hyst_a = '0, hyst_b = '0;
  logic [1:0] ext_trig_in = '0;
  logic [2:0] src_sel = '0;
  logic trig_o;

  int n_cmp = 0, n_bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  trigger_select #(.DW(DW)) u0 (.*);

  // Independent reference of the requirements
  bit up_rel [2], dn_rel [2];
  bit xs [2][3];
  int prev_code = 0;
  bit exp_trig = 1'b0;

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  always @(posedge clk) begin
    int s [2], t [2], h [2];
    bit uh [2], dh [2], xr [2];
    int code;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        up_rel[k] = 0; dn_rel[k] = 0;
        for (int j = 0; j < 3; j++) xs[k][j] = 0;
      end
      prev_code = 0;
      exp_trig = 0;
    end else begin
      s[0] = sx(ch_a_smp); s[1] = sx(ch_b_smp);
      t[0] = sx(thr_a);    t[1] = sx(thr_b);
      h[0] = int'(hyst_a); h[1] = int'(hyst_b);
      code = int'(src_sel);
      for (int k = 0; k < 2; k++) begin
        uh[k] = smp_valid && up_rel[k] && (s[k] >= t[k]);
        dh[k] = smp_valid && dn_rel[k] && (s[k] <= t[k]);
        xr[k] = xs[k][1] && !xs[k][2];
      end
      case (code)
        1: exp_trig = (prev_code != 1);
        2: exp_trig = uh[0];
        3: exp_trig = dh[0];
        4: exp_trig = uh[1];
        5: exp_trig = dh[1];
        6: exp_trig = xr[0];
        7: exp_trig = xr[1];
        default: exp_trig = 0;
      endcase
      for (int k = 0; k < 2; k++) begin
        if (smp_valid) begin
          if (uh[k]) up_rel[k] = 0; else if (s[k] < t[k] - h[k]) up_rel[k] = 1;
          if (dh[k]) dn_rel[k] = 0; else if (s[k] > t[k] + h[k]) dn_rel[k] = 1;
        end
        xs[k][2] = xs[k][1]; xs[k][1] = xs[k][0]; xs[k][0] = ext_trig_in[k];
      end
      prev_code = code;
    end
  end

  function automatic string req_of(input int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2, 4: return "R4,R6,R7";
      3, 5: return "R5,R6,R7";
      default: return "R8";
    endcase
  endfunction

  bit last_trig = 1'b0;
  int last_code = 0;
  always @(negedge clk) begin
    if (chk_en) begin
      n_cmp++;
      if (trig_o !== exp_trig) begin
        n_bad++;
        $display("FAIL %s code=%0d trig_o actual=%b expected=%b at %0t",
                 req_of(int'(src_sel)), src_sel, trig_o, exp_trig, $time);
      end
      if (last_trig && last_code == int'(src_sel)) begin
        n_cmp++;
        if (trig_o !== 1'b0) begin
          n_bad++;
          $display("FAIL R9 pulse longer than one cycle actual=%b expected=0", trig_o);
        end
      end
      last_trig = trig_o;
      last_code = int'(src_sel);
    end
  end

  function automatic logic [DW-1:0] clamp14(input int v);
    int c;
    c = v;
    if (c > 8191) c = 8191;
    if (c < -8192) c = -8192;
    return c[DW-1:0];
  endfunction

  task automatic sweep_channel(input int code, input int thr, input int hy);
    int ph, tri_v;
    @(negedge clk);
    src_sel = code[2:0];
    thr_a = clamp14(thr); thr_b = clamp14(thr);
    hyst_a = hy[DW-1:0];  hyst_b = hy[DW-1:0];
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      ph = i % 36;
      tri_v = (ph < 18) ? (ph * 2 - 18) : (54 - ph * 2);
      if ((i / 36) == 1 && (i % 3) == 0) tri_v = tri_v + ((i % 2) ? 2 : -2);
      smp_valid = (i % 7) != 3;
      ch_a_smp = clamp14(thr + tri_v);
      ch_b_smp = clamp14(thr - tri_v);
    end
  endtask

  task automatic ext_run(input int code);
    @(negedge clk);
    src_sel = code[2:0];
    for (int w = 1; w <= 4; w++) begin
      for (int i = 0; i < w; i++) begin @(negedge clk); ext_trig_in = 2'b11; end
      for (int i = 0; i < w + 1; i++) begin @(negedge clk); ext_trig_in = 2'b00; end
      @(negedge clk); ext_trig_in = (code == 6) ? 2'b10 : 2'b01;
      @(negedge clk); ext_trig_in = 2'b00;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int thr_set [5] = '{-8192, -5, 0, 7, 8191};
    int hy_set  [3] = '{0, 3, 9};
    int seq [12] = '{0, 1, 1, 1, 2, 1, 1, 0, 1, 6, 1, 1};
    src_sel = 3'd1; ext_trig_in = 2'b11; smp_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      n_cmp++;
      if (trig_o !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 trig_o during reset actual=%b expected=0", trig_o);
      end
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (5) @(negedge clk);
    ext_trig_in = 2'b00;
    // R3: immediate code sequence
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); src_sel = seq[i][2:0];
      @(negedge clk);
    end
    // R4 R5 R6 R7: threshold and hysteresis sweep per code, R2 with code 0
    for (int c = 0; c <= 5; c++) begin
      if (c == 1) continue;
      for (int ti = 0; ti < 5; ti++)
        for (int hi = 0; hi < 3; hi++)
          sweep_channel(c, thr_set[ti], hy_set[hi]);
    end
    // R8: external inputs
    ext_run(6);
    ext_run(7);
    ext_run(0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule